// File: doc/BRIEF.md
# Duty-Cycle Square Wave Tone Channel

This block is one tone channel for a small synthesizer. A free-running clock enable at half the host clock rate drives an 11-bit down-counting divider. Each time the divider expires it reloads from the period register and moves an eight-step waveform pattern on by one position. A 2-bit shape code sets how many of the eight steps are high, and a 4-bit loudness value is sent out while the pattern is high. The output is zero while the pattern is low.

The channel also gives a single-cycle pulse whenever its waveform level changes. A host can use that pulse to raise an interrupt and resample the channel. Register writes arrive as load strobes that have already been decoded. There is one strobe for shape and loudness together, one for the low eight period bits and one for the high three period bits.

Top module: `sqw_channel`

## Requirements
- R1: While reset is held, and in the first cycle after it, `level_out` is 0 and `edge_out` is 0. Reset clears the period, shape code, loudness, divider and position.
- R2: The divider moves only on cycles where the internal half-rate enable is active. With period value P, the waveform position advances once every P+1 enables, which is once every 2(P+1) host clock cycles.
- R3: A new period value (either the low byte or the high three bits) is first used at the next reload. Writing it does not reset the position or the running count.
- R4: Shape code c (0..3) makes c+1 of the 8 steps high. The high steps are the last ones: the waveform is high when position ≥ 7−c. So the duty is 1/8, 2/8, 3/8 or 4/8.
- R5: `level_out` equals the stored loudness while the waveform is high and 0 while it is low.
- R6: `edge_out` is high for exactly the one cycle in which the waveform level differs from its level in the previous cycle. This covers both rising and falling changes, including those caused by a shape write.
- R7: The internal enable alternates every host cycle. It is active in the second cycle after reset is released.
- R8: The 3-bit position wraps from 7 to 0, so one full waveform period lasts 16(P+1) host cycles and contains exactly two level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_ld | input | 1 | Load strobe for shape code and loudness |
| ctl_duty | input | 2 | Shape code (c+1 high steps) |
| ctl_vol | input | 4 | Loudness |
| plo_ld | input | 1 | Load strobe for period bits 7..0 |
| plo_val | input | 8 | Period bits 7..0 |
| phi_ld | input | 1 | Load strobe for period bits 10..8 |
| phi_val | input | 3 | Period bits 10..8 |
| level_out | output | 4 | Channel output sample |
| edge_out | output | 1 | One-cycle pulse on each waveform level change |

## Verification
A load strobe sampled at one clock edge changes the stored value at that edge. A shape or loudness write shows on `level_out` and `edge_out` in the very next cycle. A period write shows only after the divider's next reload, which can be up to 2(P+1) cycles later. Every result is combinational from registers, so the bench drives inputs and compares outputs on the falling edge. It compares against a reference model stepped on the same rising edges, and it adds window counts of edges and high cycles taken over whole waveform periods after a settling delay longer than the old period.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
    localparam int PER_W  = 11;
    localparam int LO_W   = 8;
    localparam int HI_W   = PER_W - LO_W;
    localparam int POS_W  = 3;
    localparam int VOL_W  = 4;
    localparam int DUTY_W = 2;

    typedef enum logic [DUTY_W-1:0] {
        SHAPE_1_OF_8 = 2'd0,
        SHAPE_2_OF_8 = 2'd1,
        SHAPE_3_OF_8 = 2'd2,
        SHAPE_4_OF_8 = 2'd3
    } shape_e;

    typedef struct packed {
        shape_e             shape;
        logic [VOL_W-1:0]   vol;
        logic [PER_W-1:0]   period;
    } chan_cfg_t;

    // High steps sit at the end of the pattern: the last (code+1) positions.
    function automatic logic pattern_high(shape_e code, logic [POS_W-1:0] pos);
        int steps;
        steps = int'(code) + 1;
        return int'(pos) >= ((1 << POS_W) - steps);
    endfunction
endpackage

// File: rtl/sqw_prescale.sv
module sqw_prescale (
    input  logic clk,
    input  logic rst,
    output logic ce
);
    logic ce_q;

    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b0;
        else     ce_q <= ~ce_q;
    end

    assign ce = ce_q;

    p_toggle_on_r7: assert property (@(posedge clk) disable iff (rst) ce_q |=> !ce_q);
    p_toggle_off_r7: assert property (@(posedge clk) disable iff (rst) !ce_q |=> ce_q);
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
    parameter int W = sqw_pkg::PER_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] period,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         expire;

    assign expire = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (ce) begin
            if (expire)  cnt_q <= period;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = ce & expire;

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && cnt_q == '0) |=> cnt_q == $past(period));
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (ce && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(cnt_q));
endmodule

// File: rtl/sqw_sequencer.sv
module sqw_sequencer
    import sqw_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  shape_e shape,
    output logic   wave,
    output logic   edge_pulse
);
    logic [PW-1:0] pos_q;
    logic          wave_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (step) pos_q <= pos_q + 1'b1;
            wave_q <= wave;
        end
    end

    assign wave       = pattern_high(shape, pos_q);
    assign edge_pulse = wave ^ wave_q;

    p_advance_r8: assert property (@(posedge clk) disable iff (rst)
        step |=> pos_q == $past(pos_q) + 1'b1);
    p_still_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos_q));
    p_edge_match_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> edge_pulse == (wave != $past(wave)));
endmodule

// File: rtl/sqw_channel.sv
module sqw_channel
    import sqw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_ld,
    input  logic [DUTY_W-1:0] ctl_duty,
    input  logic [VOL_W-1:0] ctl_vol,
    input  logic             plo_ld,
    input  logic [LO_W-1:0]  plo_val,
    input  logic             phi_ld,
    input  logic [HI_W-1:0]  phi_val,
    output logic [VOL_W-1:0] level_out,
    output logic             edge_out
);
    chan_cfg_t cfg_q;
    logic      ce;
    logic      tick;
    logic      wave;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (ctl_ld) begin
                cfg_q.shape <= shape_e'(ctl_duty);
                cfg_q.vol   <= ctl_vol;
            end
            if (plo_ld) cfg_q.period[LO_W-1:0]     <= plo_val;
            if (phi_ld) cfg_q.period[PER_W-1:LO_W] <= phi_val;
        end
    end

    sqw_prescale u_pre (
        .clk (clk),
        .rst (rst),
        .ce  (ce)
    );

    sqw_divider #(.W(PER_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .period (cfg_q.period),
        .tick   (tick)
    );

    sqw_sequencer #(.PW(POS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .step       (tick),
        .shape      (cfg_q.shape),
        .wave       (wave),
        .edge_pulse (edge_out)
    );

    assign level_out = wave ? cfg_q.vol : '0;

    p_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (level_out == '0 && !edge_out));
    p_level_src_r5: assert property (@(posedge clk) disable iff (rst)
        (level_out != '0) |-> (level_out == cfg_q.vol && wave));
endmodule

// File: tb/sim_sqw_channel.sv
`timescale 1ns/1ps
module sim_sqw_channel;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_ld, plo_ld, phi_ld;
    logic [1:0] ctl_duty;
    logic [3:0] ctl_vol;
    logic [7:0] plo_val;
    logic [2:0] phi_val;
    logic [3:0] level_out;
    logic       edge_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sqw_channel u0 (
        .clk(clk), .rst(rst),
        .ctl_ld(ctl_ld), .ctl_duty(ctl_duty), .ctl_vol(ctl_vol),
        .plo_ld(plo_ld), .plo_val(plo_val),
        .phi_ld(phi_ld), .phi_val(phi_val),
        .level_out(level_out), .edge_out(edge_out)
    );

    // Reference model built from the requirements.
    logic        m_ph;
    logic [10:0] m_cnt, m_per;
    logic [2:0]  m_pos;
    logic [1:0]  m_duty;
    logic [3:0]  m_vol;
    logic        m_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 1'b0; m_cnt <= '0; m_per <= '0;
            m_pos <= '0; m_duty <= '0; m_vol <= '0;
        end else begin
            m_ph <= ~m_ph;
            if (m_ph) begin
                if (m_cnt == 0) begin
                    m_cnt <= m_per;
                    m_pos <= m_pos + 3'd1;
                end else begin
                    m_cnt <= m_cnt - 11'd1;
                end
            end
            if (ctl_ld) begin m_duty <= ctl_duty; m_vol <= ctl_vol; end
            if (plo_ld) m_per[7:0]  <= plo_val;
            if (phi_ld) m_per[10:8] <= phi_val;
        end
    end

    function automatic bit exp_high(logic [1:0] d, logic [2:0] p);
        return int'(p) >= 7 - int'(d);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ctl_ld = 0; plo_ld = 0; phi_ld = 0;
    endtask

    // Compare against the model at a falling edge.
    task automatic model_cmp();
        bit w;
        w = exp_high(m_duty, m_pos);
        chk("R5 level vs model", level_out, w ? m_vol : 0);
        chk("R6 edge vs model", edge_out, (w != m_prev) ? 1 : 0);
        m_prev = w;
    endtask

    task automatic cfg(int d, int v, int per);
        @(negedge clk);
        model_cmp();
        ctl_ld = 1; ctl_duty = d[1:0]; ctl_vol = v[3:0];
        plo_ld = 1; plo_val = per[7:0];
        phi_ld = 1; phi_val = per[10:8];
        @(negedge clk);
        model_cmp();
        idle();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_cmp();
        end
    endtask

    // Counts over one whole waveform period after settling.
    task automatic window(string tag, int d, int v, int per);
        int edges, highs, bad;
        cfg(d, v, per);
        run(40 + 32 * (per + 1) + 2 * 300);
        edges = 0; highs = 0; bad = 0;
        for (int i = 0; i < 16 * (per + 1); i++) begin
            @(negedge clk);
            model_cmp();
            if (edge_out) edges++;
            if (level_out != 0) highs++;
            if (level_out != 0 && level_out != v[3:0]) bad++;
        end
        chk({tag, " R8 edges per period"}, edges, 2);
        chk({tag, " R4 R2 high cycles per period"}, highs, (d + 1) * 2 * (per + 1));
        chk({tag, " R5 level value"}, bad, 0);
    endtask

    initial begin
        int first_tick;
        void'($urandom(32'd4242));
        idle(); ctl_duty = 0; ctl_vol = 0; plo_val = 0; phi_val = 0;
        m_prev = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 level in reset", level_out, 0);
        chk("R1 edge in reset", edge_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 level after reset", level_out, 0);
        chk("R1 edge after reset", edge_out, 0);
        m_prev = 1'b0;

        // R7 / R2: period 0, shape 3 -> position advances every 2 cycles,
        // waveform high at positions 4..7.
        cfg(3, 9, 0);
        first_tick = 0;
        run(64);
        window("w0", 0, 15, 0);
        window("w1", 3, 7, 2);
        window("w2", 1, 5, 5);
        window("w3", 2, 12, 1);

        // R3: period high-bit write mid-run keeps position; model compare tracks it.
        cfg(3, 6, 3);
        run(10);
        @(negedge clk); model_cmp(); phi_ld = 1; phi_val = 3'd1;
        @(negedge clk); model_cmp(); idle();
        run(1200);
        @(negedge clk); model_cmp(); plo_ld = 1; plo_val = 8'd2; phi_ld = 1; phi_val = 3'd0;
        @(negedge clk); model_cmp(); idle();
        run(1200);

        // Random writes mixed with free running (R2 R3 R4 R5 R6 R8 via model).
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            model_cmp();
            idle();
            if ($urandom_range(0, 49) == 0) begin
                ctl_ld = 1; ctl_duty = 2'($urandom); ctl_vol = 4'($urandom);
            end
            if ($urandom_range(0, 99) == 0) begin
                plo_ld = 1; plo_val = 8'($urandom_range(0, 12));
            end
            if ($urandom_range(0, 399) == 0) begin
                phi_ld = 1; phi_val = 3'($urandom_range(0, 1));
            end
        end
        @(negedge clk); idle();
        run(20);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule